// File: doc/BRIEF.md
# Asynchronous Host Bus Port with Two-Cycle Data Memory Read

This block connects an external processor to a switching device. The processor uses an asynchronous, non-multiplexed bus: a 14-bit address, 16-bit data split into separate in and out paths with a drive enable for the pad, an active-low chip select, an active-low data strobe and a read/write line. The block returns an active-low transfer acknowledge. Chip select and strobe are brought into the core clock domain through a two-stage synchroniser. The acknowledge follows after a fixed delay. Each access is applied once, on the clock edge where the acknowledge is raised.

The address space has four regions. A small register bank holds six writable registers and two read-only status words. The connection memory can be read and written. The data memory can only be read by the host, because the switching fabric fills it. Writes to read-only locations are acknowledged and dropped.

A data memory read is pipelined. The word returned by a data memory read is the one held in a pipeline register. That register is loaded at the end of the previous data memory read cycle, from the address that cycle used. The host therefore reads the same address twice and keeps only the second result.

Top module: `host_port`

## Requirements
- R1: After reset, `ackN` is high and `dataOe` is low. Registers 0 to 5 and every connection memory word read as zero. The first data memory read after reset returns zero.
- R2: With `csN` and `dsN` both low before a rising edge, `ackN` is still high after the third rising edge and low after the fourth. This is two synchroniser stages plus a fixed two-clock delay.
- R3: After `dsN` and `csN` return high, `ackN` stays low through two rising edges and is high after the third. `dataOe` is low once `ackN` is high again.
- R4: `addr[13:12]` selects the region: 00 = register bank, indexed by `addr[2:0]`, valid only when `addr[11:3]` is zero. 11 = connection memory and 10 = data memory, both indexed by `addr[7:0]` and valid only when `addr[11:8]` is zero. Region 01 and any non-zero unused bits are unmapped. Unmapped reads return 0 and unmapped writes have no effect.
- R5: Registers 0 to 5 and the connection memory return the last value the host wrote to them.
- R6: Register 6 always reads `statusIn` and register 7 always reads `errCntIn`. Host writes to registers 6 and 7 and to the data memory are acknowledged and change nothing.
- R7: A data memory read returns the word that was stored, at the end of the previous data memory read cycle, at that cycle's address. A second read at the same address therefore returns that address's current word.
- R8: `dataOe` is high only while `ackN` is low in a read cycle. It is never high during a write cycle.
- R9: If the strobe is released before the acknowledge is given (a select lasting one clock), no acknowledge is given and no write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| dsN | input | 1 | Data strobe, active low, asynchronous |
| rdWrN | input | 1 | 1 = read, 0 = write |
| addr | input | 14 | Host address |
| dataIn | input | 16 | Write data from the host bus |
| dataOut | output | 16 | Read data toward the host bus |
| dataOe | output | 1 | Drive enable for the bus pad |
| ackN | output | 1 | Transfer acknowledge, active low |
| statusIn | input | 16 | Value of read-only register 6 |
| errCntIn | input | 16 | Value of read-only register 7 |
| fabWrEn | input | 1 | Fabric write enable for data memory |
| fabWrAddr | input | 8 | Fabric write index into data memory |
| fabWrData | input | 16 | Fabric write data |

## Verification
The pipelined read is tried with three patterns:
- a first read right after reset, which must return zero;
- two reads at one address, where the second must return the live word;
- a read at a new address after the fabric has overwritten the previous word, which must return the old captured value.

Together these tell a correct pipeline apart from a live read and from a register loaded at the wrong moment. Writes then reads to each region, with the address differing only in the unused bits, separate correct region decoding from aliasing. Writes to read-only locations, and a one-clock strobe, show that nothing was changed: the same locations are read back through the bus afterwards.

// File: rtl/host_port_pkg.sv
package host_port_pkg;

  // Region codes taken from the two top address bits
  typedef enum logic [1:0] {
    RGN_REGS = 2'b00,
    RGN_NONE = 2'b01,
    RGN_DMEM = 2'b10,
    RGN_CMEM = 2'b11
  } hpRegion_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic doWrite;  // apply a write on this edge
    logic doRead;   // capture read data on this edge
    logic finish;   // the bus cycle ends on this edge
  } hpStrobe_t;

endpackage

// File: rtl/host_port_ctrl.sv
module host_port_ctrl
  import host_port_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      dsN,
  input  logic      rdWrN,
  output hpStrobe_t strb,
  output logic      ackN,
  output logic      dataOe
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DLY  = 2'b01,
    ST_ACK  = 2'b10
  } ctrlState_t;

  ctrlState_t state, stateNext;
  logic selMeta, selSync;
  logic rdCyc;

  // Two-stage synchroniser on the combined select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selMeta <= 1'b0;
      selSync <= 1'b0;
    end else begin
      selMeta <= !csN && !dsN;
      selSync <= selMeta;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (selSync) stateNext = ST_DLY;
      ST_DLY:  stateNext = selSync ? ST_ACK : ST_IDLE;
      ST_ACK:  if (!selSync) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // The access is applied on the edge that enters ST_ACK
  always_comb begin
    strb.doWrite = (state == ST_DLY) && selSync && !rdWrN;
    strb.doRead  = (state == ST_DLY) && selSync && rdWrN;
    strb.finish  = (state == ST_ACK) && !selSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdCyc <= 1'b0;
    else if (strb.doRead)  rdCyc <= 1'b1;
    else if (strb.doWrite) rdCyc <= 1'b0;
  end

  assign ackN   = (state != ST_ACK);
  assign dataOe = (state == ST_ACK) && rdCyc;

endmodule

// File: rtl/host_port_dpath.sv
module host_port_dpath
  import host_port_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int CM_DEPTH = 256,
  parameter int DM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpStrobe_t         strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] errCntIn,
  input  logic              fabWrEn,
  input  logic [$clog2(DM_DEPTH)-1:0] fabWrAddr,
  input  logic [DATA_W-1:0] fabWrData,
  output logic [DATA_W-1:0] rdOut
);

  localparam int REG_IW     = $clog2(NUM_REGS);
  localparam int CM_AW      = $clog2(CM_DEPTH);
  localparam int DM_AW      = $clog2(DM_DEPTH);
  localparam int RGN_LSB    = ADDR_W - 2;
  localparam int STATUS_IDX = NUM_REGS - 2;
  localparam int ERRCNT_IDX = NUM_REGS - 1;

  hpRegion_t region;
  logic [REG_IW-1:0] regIdx;
  logic [CM_AW-1:0]  cmIdx;
  logic [DM_AW-1:0]  dmIdx;
  logic regHit, cmHit, dmHit;

  assign region = hpRegion_t'(addrIn[ADDR_W-1:RGN_LSB]);
  assign regIdx = addrIn[REG_IW-1:0];
  assign cmIdx  = addrIn[CM_AW-1:0];
  assign dmIdx  = addrIn[DM_AW-1:0];

  // A region is hit only when the bits between its index and the region code are zero
  assign regHit = (region == RGN_REGS) && (addrIn[RGN_LSB-1:REG_IW] == '0);
  assign cmHit  = (region == RGN_CMEM) && (addrIn[RGN_LSB-1:CM_AW] == '0);
  assign dmHit  = (region == RGN_DMEM) && (addrIn[RGN_LSB-1:DM_AW] == '0);

  // Register bank: the last two entries are read-only status inputs
  logic [DATA_W-1:0] regVal [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    if (g == STATUS_IDX) begin : gStatus
      assign regVal[g] = statusIn;
    end else if (g == ERRCNT_IDX) begin : gErrCnt
      assign regVal[g] = errCntIn;
    end else begin : gRw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (strb.doWrite && regHit && regIdx == REG_IW'(g)) q <= dataIn;
      end
      assign regVal[g] = q;
    end
  end

  // Connection memory: host read/write
  logic [DATA_W-1:0] cmMem [CM_DEPTH];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CM_DEPTH; i++) cmMem[i] <= '0;
    end else if (strb.doWrite && cmHit) begin
      cmMem[cmIdx] <= dataIn;
    end
  end

  // Data memory: written by the fabric only
  logic [DATA_W-1:0] dmMem [DM_DEPTH];
  always_ff @(posedge clk) begin
    if (fabWrEn) dmMem[fabWrAddr] <= fabWrData;
  end

  // Pipeline register loaded when a data memory read cycle ends
  logic              pendDm;
  logic [DM_AW-1:0]  pendIdx;
  logic [DATA_W-1:0] pipeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendDm  <= 1'b0;
      pendIdx <= '0;
      pipeReg <= '0;
    end else begin
      if (strb.doRead && dmHit) begin
        pendDm  <= 1'b1;
        pendIdx <= dmIdx;
      end else if (strb.finish) begin
        pendDm <= 1'b0;
        if (pendDm) pipeReg <= dmMem[pendIdx];
      end
    end
  end

  // Read selection
  logic [DATA_W-1:0] rdSel;
  always_comb begin
    rdSel = '0;
    if (regHit)     rdSel = regVal[regIdx];
    else if (cmHit) rdSel = cmMem[cmIdx];
    else if (dmHit) rdSel = pipeReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdOut <= '0;
    else if (strb.doRead) rdOut <= rdSel;
  end

endmodule

// File: rtl/host_port.sv
module host_port
  import host_port_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int CM_DEPTH = 256,
  parameter int DM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              dsN,
  input  logic              rdWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              ackN,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] errCntIn,
  input  logic              fabWrEn,
  input  logic [$clog2(DM_DEPTH)-1:0] fabWrAddr,
  input  logic [DATA_W-1:0] fabWrData
);

  hpStrobe_t strb;

  host_port_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .dsN    (dsN),
    .rdWrN  (rdWrN),
    .strb   (strb),
    .ackN   (ackN),
    .dataOe (dataOe)
  );

  host_port_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .CM_DEPTH (CM_DEPTH),
    .DM_DEPTH (DM_DEPTH)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addrIn    (addr),
    .dataIn    (dataIn),
    .statusIn  (statusIn),
    .errCntIn  (errCntIn),
    .fabWrEn   (fabWrEn),
    .fabWrAddr (fabWrAddr),
    .fabWrData (fabWrData),
    .rdOut     (dataOut)
  );

endmodule

// File: rtl/host_port_chk.sv
module host_port_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic dsN,
  input logic rdWrN,
  input logic ackN,
  input logic dataOe
);

  // Independent model of the synchronised select and its age
  logic selA, selB;
  logic [1:0] age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selA <= 1'b0;
      selB <= 1'b0;
      age  <= '0;
    end else begin
      selA <= !csN && !dsN;
      selB <= selA;
      if (!selB)           age <= '0;
      else if (age != 2'd2) age <= age + 2'd1;
    end
  end

  // R2: acknowledge only once the select has been seen for two clocks
  p_ack_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackN == (age < 2'd2));

  // R3: acknowledge held while the select stays active
  p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ackN && selB) |=> !ackN);

  // R3: acknowledge released one clock after the synchronised select drops
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ackN && !selB) |=> ackN);

  // R8: the bus is driven only during an acknowledged cycle
  p_oe_in_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !ackN);

  // R8: write cycles never drive the bus
  p_oe_not_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ackN && !rdWrN) |-> !dataOe);

  // R8: read cycles drive the bus as the acknowledge appears
  p_oe_on_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ackN) && rdWrN) |-> dataOe);

endmodule

bind host_port host_port_chk uChk (
  .clk    (clk),
  .rstN   (rstN),
  .csN    (csN),
  .dsN    (dsN),
  .rdWrN  (rdWrN),
  .ackN   (ackN),
  .dataOe (dataOe)
);

// File: tb/host_port_bench.sv
`timescale 1ns/1ps
module host_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, dsN = 1'b1, rdWrN = 1'b1;
  logic [13:0] addr = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataOe, ackN;
  logic [15:0] statusIn = 16'h0f0f, errCntIn = 16'h1234;
  logic        fabWrEn = 1'b0;
  logic [7:0]  fabWrAddr = '0;
  logic [15:0] fabWrData = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  host_port u_host_port (
    .clk(clk), .rstN(rstN), .csN(csN), .dsN(dsN), .rdWrN(rdWrN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .ackN(ackN), .statusIn(statusIn), .errCntIn(errCntIn),
    .fabWrEn(fabWrEn), .fabWrAddr(fabWrAddr), .fabWrData(fabWrData)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One full bus cycle; returns read data and edge counts
  task automatic busCycle(input logic isRd, input logic [13:0] a, input logic [15:0] wd,
                          output logic [15:0] rd, output int ackEdges,
                          output int relEdges, output logic oeAtAck,
                          output logic oeAfter);
    @(negedge clk);
    addr = a; dataIn = wd; rdWrN = isRd; csN = 1'b0; dsN = 1'b0;
    ackEdges = 0;
    do begin
      @(posedge clk); #1; ackEdges++;
    end while (ackN && ackEdges < 20);
    rd = dataOut;
    oeAtAck = dataOe;
    @(negedge clk);
    dsN = 1'b1; csN = 1'b1;
    relEdges = 0;
    do begin
      @(posedge clk); #1; relEdges++;
    end while (!ackN && relEdges < 20);
    oeAfter = dataOe;
  endtask

  task automatic hostWr(input logic [13:0] a, input logic [15:0] d);
    logic [15:0] rd; int ae, re; logic o1, o2;
    busCycle(1'b0, a, d, rd, ae, re, o1, o2);
  endtask

  task automatic hostRd(input logic [13:0] a, output logic [15:0] d);
    int ae, re; logic o1, o2;
    busCycle(1'b1, a, 16'h0, d, ae, re, o1, o2);
  endtask

  task automatic fabWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    fabWrEn = 1'b1; fabWrAddr = a; fabWrData = d;
    @(negedge clk);
    fabWrEn = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] rd;
    check("R1", "ackN after reset", 32'(ackN), 32'h1);
    check("R1", "dataOe after reset", 32'(dataOe), 32'h0);
    hostRd(14'h0000, rd);
    check("R1", "reg0 reset value", 32'(rd), 32'h0);
    hostRd(14'h3005, rd);
    check("R1", "cm[5] reset value", 32'(rd), 32'h0);
  endtask

  task automatic t_pipeline();
    logic [15:0] rd;
    fabWrite(8'h03, 16'h0303);
    fabWrite(8'h04, 16'h0404);
    hostRd(14'h2003, rd);
    check("R1", "first dm read after reset", 32'(rd), 32'h0);
    hostRd(14'h2003, rd);
    check("R7", "second read same address", 32'(rd), 32'h0303);
    fabWrite(8'h03, 16'h7777);
    hostRd(14'h2004, rd);
    check("R7", "first read new address gives old capture", 32'(rd), 32'h0303);
    hostRd(14'h2004, rd);
    check("R7", "second read new address", 32'(rd), 32'h0404);
  endtask

  task automatic t_timing();
    logic [15:0] rd; int ae, re; logic oeAck, oeAft;
    busCycle(1'b0, 14'h0001, 16'h1111, rd, ae, re, oeAck, oeAft);
    check("R2", "write: edges to ack", 32'(ae), 32'd4);
    check("R3", "write: edges to release", 32'(re), 32'd3);
    check("R8", "write: oe during ack", 32'(oeAck), 32'h0);
    busCycle(1'b1, 14'h0001, 16'h0, rd, ae, re, oeAck, oeAft);
    check("R2", "read: edges to ack", 32'(ae), 32'd4);
    check("R8", "read: oe during ack", 32'(oeAck), 32'h1);
    check("R3", "read: edges to release", 32'(re), 32'd3);
    check("R3", "read: oe after release", 32'(oeAft), 32'h0);
    check("R5", "reg1 readback", 32'(rd), 32'h1111);
  endtask

  task automatic t_readWrite();
    logic [15:0] rd;
    hostWr(14'h0000, 16'h1234);
    hostWr(14'h0005, 16'habcd);
    hostWr(14'h3000, 16'h5555);
    hostWr(14'h30ff, 16'haaaa);
    hostRd(14'h0000, rd); check("R5", "reg0", 32'(rd), 32'h1234);
    hostRd(14'h0005, rd); check("R5", "reg5", 32'(rd), 32'habcd);
    hostRd(14'h3000, rd); check("R5", "cm[0]", 32'(rd), 32'h5555);
    hostRd(14'h30ff, rd); check("R5", "cm[255]", 32'(rd), 32'haaaa);
  endtask

  task automatic t_decode();
    logic [15:0] rd;
    hostWr(14'h3005, 16'h0505);
    hostRd(14'h3105, rd); check("R4", "cm alias with unused bit set", 32'(rd), 32'h0);
    hostRd(14'h0008, rd); check("R4", "reg alias with unused bit set", 32'(rd), 32'h0);
    hostWr(14'h1000, 16'hbeef);
    hostRd(14'h1000, rd); check("R4", "unmapped region read", 32'(rd), 32'h0);
    hostRd(14'h3005, rd); check("R4", "cm[5] untouched by aliases", 32'(rd), 32'h0505);
    hostRd(14'h0000, rd); check("R4", "reg0 untouched by unmapped write", 32'(rd), 32'h1234);
  endtask

  task automatic t_readOnly();
    logic [15:0] rd;
    hostWr(14'h0006, 16'hffff);
    hostWr(14'h0007, 16'hffff);
    hostRd(14'h0006, rd); check("R6", "reg6 ignores write", 32'(rd), 32'h0f0f);
    hostRd(14'h0007, rd); check("R6", "reg7 ignores write", 32'(rd), 32'h1234);
    @(negedge clk); statusIn = 16'h00a5; errCntIn = 16'h0042;
    hostRd(14'h0006, rd); check("R6", "reg6 follows input", 32'(rd), 32'h00a5);
    hostRd(14'h0007, rd); check("R6", "reg7 follows input", 32'(rd), 32'h0042);
    fabWrite(8'h10, 16'h1111);
    hostWr(14'h2010, 16'hdead);
    hostRd(14'h2010, rd);
    hostRd(14'h2010, rd); check("R6", "dm ignores host write", 32'(rd), 32'h1111);
  endtask

  task automatic t_abort();
    logic [15:0] rd;
    logic sawAck;
    hostWr(14'h0002, 16'h2222);
    @(negedge clk);
    addr = 14'h0002; dataIn = 16'h9999; rdWrN = 1'b0; csN = 1'b0; dsN = 1'b0;
    @(negedge clk);
    csN = 1'b1; dsN = 1'b1;
    sawAck = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (!ackN) sawAck = 1'b1;
    end
    check("R9", "no ack for one-clock select", 32'(sawAck), 32'h0);
    hostRd(14'h0002, rd);
    check("R9", "aborted write had no effect", 32'(rd), 32'h2222);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_pipeline();
    t_timing();
    t_readWrite();
    t_decode();
    t_readOnly();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule